// File: doc/BRIEF.md
# Load/Store Multiple Register Sequencer

This block carries out one load-multiple or store-multiple operation for a processor core. When `start` is accepted, it captures these inputs: a base address, a 5-bit register-list field, a load/store direction, a 32/64-bit word-size select and a privilege index. It then runs a series of single-word memory transfers. Only one transfer is outstanding at any time. Each request uses a valid/ready handshake, and the block waits for the matching response before it moves to the next transfer.

The register list is not a bitmask. Its low four bits hold a count. The count selects how many entries are taken, from the front, of a fixed register table: 16, 17, 18, 19, 20, 21, 22, 23, 30. Bit 4 of the field requests one further transfer of register 31, which comes after the counted group.

On a load, each returned word goes to the register file through a write port. On a store, each register is read through a read port, and the value read is sent with the request. A one-cycle `done` pulse marks the end of the operation.

Top module: `lsm_sequencer`

## Requirements
- R1: The count N is `reg_list[3:0]` and the flag is `reg_list[4]`. N counted transfers are made only when N is 1 to 9. For N = 0 or N > 9, no counted transfer is made. A set flag adds exactly one more transfer, so the number of requests is (N valid ? N : 0) + flag.
- R2: Counted transfer i (starting at 0) uses register 16+i for i < 8 and register 30 for i = 8. When the flag is set, the final transfer uses register 31.
- R3: Transfer i uses address base + i*4 when `dword`=0 and base + i*8 when `dword`=1. The register-31 transfer therefore uses the base address when the counted group is skipped.
- R4: Every request carries `mreq_priv`. It is 0 (kernel) for a privilege index of 0, 1 (supervisor) for 1, and 2 (user) for 2 or 3. `mreq_dword` repeats the captured word size.
- R5: At most one request is outstanding. While `mreq_valid` is high and `mreq_ready` is low, the request and its address stay unchanged. No new request is raised until the response (`mrsp_valid`) to the previous one has arrived.
- R6: On a load (`mreq_we`=0), `rf_we` is high exactly in the cycle `mrsp_valid` is high. `rf_waddr` gives the register for that transfer. `rf_wdata` carries the full word when `dword`=1, and `mrsp_rdata[31:0]` sign-extended when `dword`=0.
- R7: On a store (`mreq_we`=1), the register is read through `rf_raddr` in the cycle before the request is raised. That value, unchanged, is sent on `mreq_wdata`. A store never asserts `rf_we`.
- R8: `done` is high for exactly one cycle, in the cycle after the last response. When no transfer is needed, it is high in the cycle after `start`, and no request is made.
- R9: `start` is ignored from acceptance until the cycle after `done`. Inputs presented with it then do not alter the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| base_addr | input | AW | First transfer address |
| reg_list | input | 5 | Count in [3:0], register-31 flag in [4] |
| is_load | input | 1 | 1 = load, 0 = store |
| dword | input | 1 | 1 = 64-bit words, 0 = 32-bit words |
| priv_in | input | 2 | Privilege index |
| mreq_valid | output | 1 | Memory request valid |
| mreq_ready | input | 1 | Memory request accepted |
| mreq_addr | output | AW | Request address |
| mreq_we | output | 1 | 1 = write (store) |
| mreq_dword | output | 1 | Request word size |
| mreq_priv | output | 2 | Privilege code 0/1/2 |
| mreq_wdata | output | XLEN | Store data |
| mrsp_valid | input | 1 | Memory response valid |
| mrsp_rdata | input | XLEN | Load data |
| rf_raddr | output | 5 | Register file read index |
| rf_rdata | input | XLEN | Register file read data |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 5 | Register file write index |
| rf_wdata | output | XLEN | Register file write data |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench covers counts that fall outside 1 to 9, with and without the register-31 flag. A design that bounded the count wrongly would issue requests, or leave out the register-31 transfer at the base address. A full nine-register list, run in 32-bit mode over alternating-sign words, exposes three faults: a wrong entry for register 30, a wrong stride, or a missing sign extension. Privilege index 3 must map to user, and stalls on `mreq_ready` must leave the address unchanged. A `start` pulse in the middle of an operation must not restart it or add a second `done`. The zero-transfer case is timed to one cycle.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

  localparam int unsigned CNT_W        = 4;
  localparam int unsigned LIST_W       = CNT_W + 1;
  localparam int unsigned REG_W        = 5;
  localparam int unsigned TBL_LEN      = 9;
  localparam int unsigned TBL_RUN_LEN  = 8;
  localparam int unsigned TBL_RUN_BASE = 16;
  localparam int unsigned TBL_TAIL_REG = 30;
  localparam int unsigned LINK_REG     = 31;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_REQ,
    ST_RSP,
    ST_DONE
  } lsm_state_e;

  localparam logic [1:0] PRV_KERNEL = 2'd0;
  localparam logic [1:0] PRV_SUPER  = 2'd1;
  localparam logic [1:0] PRV_USER   = 2'd2;

  function automatic logic [1:0] priv_map(input logic [1:0] idx);
    case (idx)
      2'd0:    priv_map = PRV_KERNEL;
      2'd1:    priv_map = PRV_SUPER;
      default: priv_map = PRV_USER;
    endcase
  endfunction

endpackage

// File: rtl/lsm_listdec.sv
module lsm_listdec
  import lsm_pkg::*;
(
  input  logic [LIST_W-1:0] reg_list,
  output logic [CNT_W-1:0]  cnt_eff,
  output logic [CNT_W-1:0]  total,
  output logic              zero
);

  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(TBL_LEN);

  logic [CNT_W-1:0] raw_cnt;
  logic             in_range;
  logic             link_f;

  assign raw_cnt  = reg_list[CNT_W-1:0];
  assign link_f   = reg_list[CNT_W];
  assign in_range = (raw_cnt != '0) && (raw_cnt <= MAX_CNT);

  always_comb begin
    cnt_eff = in_range ? raw_cnt : '0;
    total   = cnt_eff + {{(CNT_W-1){1'b0}}, link_f};
    zero    = (total == '0);
  end

endmodule

// File: rtl/lsm_regmap.sv
module lsm_regmap
  import lsm_pkg::*;
(
  input  logic [CNT_W-1:0] idx,
  input  logic [CNT_W-1:0] cnt_eff,
  output logic [REG_W-1:0] reg_num
);

  logic [REG_W-1:0] tbl [TBL_LEN];

  for (genvar g = 0; g < TBL_LEN; g++) begin : g_tbl
    if (g < TBL_RUN_LEN) begin : g_run
      assign tbl[g] = REG_W'(TBL_RUN_BASE + g);
    end else begin : g_tail
      assign tbl[g] = REG_W'(TBL_TAIL_REG);
    end
  end

  logic [REG_W-1:0] tbl_sel;

  always_comb begin
    tbl_sel = REG_W'(LINK_REG);
    for (int g = 0; g < TBL_LEN; g++) begin
      if (idx == CNT_W'(g)) tbl_sel = tbl[g];
    end
    reg_num = (idx < cnt_eff) ? tbl_sel : REG_W'(LINK_REG);
  end

endmodule

// File: rtl/lsm_agen.sv
module lsm_agen #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [AW-1:0] base,
  input  logic          adv,
  input  logic          dword,
  output logic [AW-1:0] addr
);

  localparam logic [AW-1:0] STEP_W = AW'(4);
  localparam logic [AW-1:0] STEP_D = AW'(8);

  logic [AW-1:0] addr_q;
  logic [AW-1:0] addr_d;
  logic          addr_en;

  always_comb begin
    addr_en = load_en | adv;
    addr_d  = load_en ? base : (addr_q + (dword ? STEP_D : STEP_W));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end

  assign addr = addr_q;

  p_stride_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load_en) |=> (addr_q == $past(addr_q) + ($past(dword) ? STEP_D : STEP_W)));

endmodule

// File: rtl/lsm_fsm.sv
module lsm_fsm
  import lsm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             is_load_in,
  input  logic             zero_in,
  input  logic             ld_q,
  input  logic [CNT_W-1:0] total_q,
  input  logic             mreq_ready,
  input  logic             mrsp_valid,
  output lsm_state_e       state,
  output logic             accept,
  output logic             fetch_en,
  output logic             req_valid,
  output logic             adv,
  output logic             done,
  output logic [CNT_W-1:0] idx
);

  lsm_state_e       state_q, state_d;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic             idx_en;
  logic             last;

  assign last = (idx_q == (total_q - CNT_W'(1)));

  always_comb begin
    state_d   = state_q;
    accept    = 1'b0;
    fetch_en  = 1'b0;
    req_valid = 1'b0;
    adv       = 1'b0;
    done      = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          accept = 1'b1;
          if (zero_in)         state_d = ST_DONE;
          else if (is_load_in) state_d = ST_REQ;
          else                 state_d = ST_FETCH;
        end
      end
      ST_FETCH: begin
        fetch_en = 1'b1;
        state_d  = ST_REQ;
      end
      ST_REQ: begin
        req_valid = 1'b1;
        if (mreq_ready) state_d = ST_RSP;
      end
      ST_RSP: begin
        if (mrsp_valid) begin
          adv = 1'b1;
          if (last)      state_d = ST_DONE;
          else if (ld_q) state_d = ST_REQ;
          else           state_d = ST_FETCH;
        end
      end
      ST_DONE: begin
        done    = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    idx_en = accept | adv;
    idx_d  = accept ? '0 : (idx_q + CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  assign state = state_q;
  assign idx   = idx_q;

  p_one_outstanding_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mreq_ready) |=> !req_valid);

  p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !mreq_ready) |=> req_valid);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_zero_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && zero_in) |=> (done && !req_valid));

endmodule

// File: rtl/lsm_sequencer.sv
module lsm_sequencer
  import lsm_pkg::*;
#(
  parameter int unsigned AW   = 32,
  parameter int unsigned XLEN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AW-1:0]     base_addr,
  input  logic [4:0]        reg_list,
  input  logic              is_load,
  input  logic              dword,
  input  logic [1:0]        priv_in,
  output logic              mreq_valid,
  input  logic              mreq_ready,
  output logic [AW-1:0]     mreq_addr,
  output logic              mreq_we,
  output logic              mreq_dword,
  output logic [1:0]        mreq_priv,
  output logic [XLEN-1:0]   mreq_wdata,
  input  logic              mrsp_valid,
  input  logic [XLEN-1:0]   mrsp_rdata,
  output logic [4:0]        rf_raddr,
  input  logic [XLEN-1:0]   rf_rdata,
  output logic              rf_we,
  output logic [4:0]        rf_waddr,
  output logic [XLEN-1:0]   rf_wdata,
  output logic              done
);

  // reset: asserted asynchronously, released on the clock
  logic rst_s0, rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0 <= 1'b0;
      rst_s  <= 1'b0;
    end else begin
      rst_s0 <= 1'b1;
      rst_s  <= rst_s0;
    end
  end

  // list decode of the live input, captured on acceptance
  logic [CNT_W-1:0] cnt_live, total_live;
  logic             zero_live;

  lsm_listdec i_listdec (
    .reg_list (reg_list),
    .cnt_eff  (cnt_live),
    .total    (total_live),
    .zero     (zero_live)
  );

  lsm_state_e       state;
  logic             accept, fetch_en, req_valid, adv;
  logic [CNT_W-1:0] idx;
  logic [CNT_W-1:0] cnt_q, total_q;
  logic             ld_q, dbl_q;
  logic [1:0]       priv_q;
  logic [XLEN-1:0]  wdata_q;
  logic [REG_W-1:0] reg_num;
  logic [AW-1:0]    addr;
  logic             busy;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      cnt_q   <= '0;
      total_q <= '0;
      ld_q    <= 1'b0;
      dbl_q   <= 1'b0;
      priv_q  <= PRV_KERNEL;
    end else if (accept) begin
      cnt_q   <= cnt_live;
      total_q <= total_live;
      ld_q    <= is_load;
      dbl_q   <= dword;
      priv_q  <= priv_map(priv_in);
    end
  end

  lsm_fsm i_fsm (
    .clk        (clk),
    .rst_n      (rst_s),
    .start      (start),
    .is_load_in (is_load),
    .zero_in    (zero_live),
    .ld_q       (ld_q),
    .total_q    (total_q),
    .mreq_ready (mreq_ready),
    .mrsp_valid (mrsp_valid),
    .state      (state),
    .accept     (accept),
    .fetch_en   (fetch_en),
    .req_valid  (req_valid),
    .adv        (adv),
    .done       (done),
    .idx        (idx)
  );

  lsm_regmap i_regmap (
    .idx     (idx),
    .cnt_eff (cnt_q),
    .reg_num (reg_num)
  );

  lsm_agen #(.AW(AW)) i_agen (
    .clk     (clk),
    .rst_n   (rst_s),
    .load_en (accept),
    .base    (base_addr),
    .adv     (adv),
    .dword   (dbl_q),
    .addr    (addr)
  );

  // store data captured during the read cycle
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      wdata_q <= '0;
    end else if (fetch_en) begin
      wdata_q <= rf_rdata;
    end
  end

  logic [XLEN-1:0] ext_word;

  if (XLEN > 32) begin : g_wide
    assign ext_word = {{(XLEN-32){mrsp_rdata[31]}}, mrsp_rdata[31:0]};

    p_sign_ext_r6: assert property (@(posedge clk) disable iff (!rst_s)
      (rf_we && !mreq_dword) |->
        ((rf_wdata[XLEN-1:32] == '0) || (&rf_wdata[XLEN-1:32])) &&
        (rf_wdata[32] == rf_wdata[31]));
  end else begin : g_narrow
    assign ext_word = mrsp_rdata;
  end

  assign busy       = (state != ST_IDLE);
  assign mreq_valid = req_valid;
  assign mreq_addr  = addr;
  assign mreq_we    = ~ld_q;
  assign mreq_dword = dbl_q;
  assign mreq_priv  = priv_q;
  assign mreq_wdata = wdata_q;
  assign rf_raddr   = reg_num;
  assign rf_we      = adv & ld_q;
  assign rf_waddr   = reg_num;
  assign rf_wdata   = dbl_q ? mrsp_rdata : ext_word;

  p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_s)
    (mreq_valid && !mreq_ready) |=> (mreq_valid && $stable(mreq_addr) && $stable(mreq_wdata)));

  p_priv_code_r4: assert property (@(posedge clk) disable iff (!rst_s)
    mreq_valid |-> (mreq_priv != 2'd3));

  p_write_on_rsp_r6: assert property (@(posedge clk) disable iff (!rst_s)
    rf_we |-> (mrsp_valid && !mreq_we));

  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_s)
    (busy && start) |=> ($stable(total_q) && $stable(ld_q) && $stable(priv_q)));

endmodule

// File: tb/test_lsm_sequencer.sv
module test_lsm_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam int AW   = 32;
  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            start;
  logic [AW-1:0]   base_addr;
  logic [4:0]      reg_list;
  logic            is_load;
  logic            dword;
  logic [1:0]      priv_in;
  logic            mreq_valid;
  logic            mreq_ready;
  logic [AW-1:0]   mreq_addr;
  logic            mreq_we;
  logic            mreq_dword;
  logic [1:0]      mreq_priv;
  logic [XLEN-1:0] mreq_wdata;
  logic            mrsp_valid;
  logic [XLEN-1:0] mrsp_rdata;
  logic [4:0]      rf_raddr;
  logic [XLEN-1:0] rf_rdata;
  logic            rf_we;
  logic [4:0]      rf_waddr;
  logic [XLEN-1:0] rf_wdata;
  logic            done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  lsm_sequencer #(.AW(AW), .XLEN(XLEN)) i_lsm_sequencer (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .reg_list(reg_list), .is_load(is_load), .dword(dword), .priv_in(priv_in),
    .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_addr(mreq_addr),
    .mreq_we(mreq_we), .mreq_dword(mreq_dword), .mreq_priv(mreq_priv),
    .mreq_wdata(mreq_wdata), .mrsp_valid(mrsp_valid), .mrsp_rdata(mrsp_rdata),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata), .done(done)
  );

  function automatic logic [XLEN-1:0] mem_word(input logic [AW-1:0] a);
    return {a ^ 32'hCAFE_0000, a[2], 7'h35, a[23:0]};
  endfunction

  function automatic logic [XLEN-1:0] rf_val(input logic [4:0] r);
    return {24'hA1B2C3, 3'b000, r, 24'h5D6E7F, 3'b000, r};
  endfunction

  assign rf_rdata = rf_val(rf_raddr);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // memory responder: ready after a configurable stall, response one cycle later
  int stall_cfg = 0;
  int wctr = 0;
  bit due = 0;
  logic [AW-1:0] due_addr;

  always @(negedge clk) begin
    if (due) begin
      mrsp_valid = 1'b1;
      mrsp_rdata = mem_word(due_addr);
      due = 0;
    end else begin
      mrsp_valid = 1'b0;
    end
    if (mreq_valid) begin
      if (wctr >= stall_cfg) begin
        mreq_ready = 1'b1;
        due = 1;
        due_addr = mreq_addr;
        wctr = 0;
      end else begin
        mreq_ready = 1'b0;
        wctr++;
      end
    end else begin
      mreq_ready = 1'b0;
      wctr = 0;
    end
  end

  // monitor, sampling in the middle of the low phase
  logic [AW-1:0]   lg_addr  [16];
  logic            lg_we    [16];
  logic            lg_dw    [16];
  logic [1:0]      lg_priv  [16];
  logic [XLEN-1:0] lg_wdata [16];
  logic [4:0]      lg_wreg  [16];
  logic [XLEN-1:0] lg_wval  [16];
  int n_req, n_wr, n_done, done_cyc, last_rsp_cyc, start_cyc, hold_err, ovl_err;
  bit seen_start, outstanding, stalled;
  logic [AW-1:0] stall_addr;

  task automatic clear_log();
    n_req = 0; n_wr = 0; n_done = 0; done_cyc = -1; last_rsp_cyc = -1;
    start_cyc = -1; hold_err = 0; ovl_err = 0; seen_start = 0;
    outstanding = 0; stalled = 0;
  endtask

  always @(negedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n) begin
      if (start && !seen_start) begin
        seen_start = 1; start_cyc = cyc;
      end
      if (mrsp_valid) begin
        last_rsp_cyc = cyc; outstanding = 0;
      end
      if (mreq_valid) begin
        if (stalled && mreq_addr != stall_addr) hold_err++;
        if (mreq_ready) begin
          if (outstanding) ovl_err++;
          if (n_req < 16) begin
            lg_addr[n_req] = mreq_addr; lg_we[n_req] = mreq_we;
            lg_dw[n_req] = mreq_dword; lg_priv[n_req] = mreq_priv;
            lg_wdata[n_req] = mreq_wdata;
          end
          n_req++; outstanding = 1; stalled = 0;
        end else begin
          stalled = 1; stall_addr = mreq_addr;
        end
      end
      if (rf_we) begin
        if (n_wr < 16) begin
          lg_wreg[n_wr] = rf_waddr; lg_wval[n_wr] = rf_wdata;
        end
        n_wr++;
      end
      if (done) begin
        n_done++; if (done_cyc < 0) done_cyc = cyc;
      end
    end
  end

  function automatic logic [4:0] exp_reg(input int i, input int cnt);
    if (i < cnt) return (i < 8) ? 5'(16 + i) : 5'd30;
    return 5'd31;
  endfunction

  task automatic run_seq(input logic [AW-1:0] base, input logic [4:0] rl, input bit ld,
                         input bit dw, input logic [1:0] pv, input int stall, input bit poke);
    int cnt, total, waitc;
    logic [1:0] exp_pv;
    cnt    = (rl[3:0] >= 1 && rl[3:0] <= 9) ? int'(rl[3:0]) : 0;
    total  = cnt + int'(rl[4]);
    exp_pv = (pv == 2'd0) ? 2'd0 : (pv == 2'd1) ? 2'd1 : 2'd2;
    stall_cfg = stall;
    @(negedge clk);
    clear_log();
    start = 1; base_addr = base; reg_list = rl; is_load = ld; dword = dw; priv_in = pv;
    @(negedge clk);
    start = 0; base_addr = ~base; reg_list = ~rl; is_load = ~ld; dword = ~dw;
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1; reg_list = 5'b11001; priv_in = 2'd0;
      @(negedge clk);
      start = 0;
    end
    waitc = 0;
    while (n_done == 0 && waitc < 500) begin
      @(negedge clk); waitc++;
    end
    repeat (4) @(negedge clk);
    check(n_req == total, "R1", "request count", 64'(n_req), 64'(total));
    check(n_done == 1, "R8", "done pulses", 64'(n_done), 64'd1);
    if (total == 0)
      check(done_cyc == start_cyc + 1, "R8", "zero-transfer done cycle",
            64'(done_cyc), 64'(start_cyc + 1));
    else
      check(done_cyc == last_rsp_cyc + 1, "R8", "done after last response",
            64'(done_cyc), 64'(last_rsp_cyc + 1));
    check(hold_err == 0 && ovl_err == 0, "R5", "hold/outstanding errors",
          64'(hold_err + ovl_err), 64'd0);
    check(n_wr == (ld ? total : 0), ld ? "R6" : "R7", "register writes",
          64'(n_wr), 64'(ld ? total : 0));
    for (int i = 0; i < total && i < n_req && i < 16; i++) begin
      logic [AW-1:0] ea;
      logic [XLEN-1:0] w, ed;
      ea = base + AW'(i * (dw ? 8 : 4));
      check(lg_addr[i] == ea, "R3", "address", 64'(lg_addr[i]), 64'(ea));
      check(lg_priv[i] == exp_pv && lg_dw[i] == dw, "R4", "privilege/size",
            64'({lg_dw[i], lg_priv[i]}), 64'({dw, exp_pv}));
      check(lg_we[i] == !ld, "R7", "write flag", 64'(lg_we[i]), 64'(!ld));
      if (ld) begin
        if (i < n_wr) begin
          w  = mem_word(ea);
          ed = dw ? w : {{32{w[31]}}, w[31:0]};
          check(lg_wreg[i] == exp_reg(i, cnt), "R2", "load register",
                64'(lg_wreg[i]), 64'(exp_reg(i, cnt)));
          check(lg_wval[i] == ed, "R6", "load data", lg_wval[i], ed);
        end
      end else begin
        check(lg_wdata[i] == rf_val(exp_reg(i, cnt)), "R7", "store data (R2 order)",
              lg_wdata[i], rf_val(exp_reg(i, cnt)));
      end
    end
  endtask

  task automatic t_reset();
    check(mreq_valid == 1'b0, "R5", "no request after reset", 64'(mreq_valid), 64'd0);
    check(rf_we == 1'b0, "R6", "no write after reset", 64'(rf_we), 64'd0);
    check(done == 1'b0, "R8", "done low after reset", 64'(done), 64'd0);
  endtask

  task automatic t_load32_short();   run_seq(32'h0000_1000, 5'b00011, 1, 0, 2'd0, 0, 0); endtask
  task automatic t_load64_full();    run_seq(32'h2000_0040, 5'b11001, 1, 1, 2'd1, 1, 0); endtask
  task automatic t_load32_nine();    run_seq(32'h0000_5004, 5'b01001, 1, 0, 2'd2, 0, 0); endtask
  task automatic t_store32_link();   run_seq(32'h0000_0300, 5'b10101, 0, 0, 2'd2, 2, 0); endtask
  task automatic t_store64_onlyr31();run_seq(32'h0000_4000, 5'b10000, 0, 1, 2'd3, 0, 0); endtask
  task automatic t_load_badcnt_r31();run_seq(32'h0000_6008, 5'b11010, 1, 0, 2'd0, 1, 0); endtask
  task automatic t_zero_load();      run_seq(32'h0000_7000, 5'b01100, 1, 0, 2'd1, 0, 0); endtask
  task automatic t_zero_store();     run_seq(32'h0000_7100, 5'b00000, 0, 1, 2'd0, 0, 0); endtask
  task automatic t_busy_ignore_r9(); run_seq(32'h0000_8000, 5'b00100, 0, 0, 2'd1, 1, 1); endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; base_addr = '0; reg_list = '0; is_load = 1'b0;
    dword = 1'b0; priv_in = '0; mreq_ready = 1'b0; mrsp_valid = 1'b0; mrsp_rdata = '0;
    clear_log();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_load32_short();
    t_load64_full();
    t_load32_nine();
    t_store32_link();
    t_store64_onlyr31();
    t_load_badcnt_r31();
    t_zero_load();
    t_zero_store();
    t_busy_ignore_r9();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule